// File: doc/BRIEF.md
# Paged Address Composer and Decoder

This block builds full-width addresses for three kinds of access and decides which memory space each one lands in. A data access picks one of several page registers, one per data address generator, and places its 8-bit value above a 16-bit index to form a 24-bit address. An indirect branch places a dedicated branch page register above a 16-bit register value. An I/O access joins an I/O page register above a 10-bit immediate to give an 18-bit I/O address.

The top 8 bits of a 24-bit address (its page) pick the target. Page 0 is internal memory and page 255 is the boot ROM. The remaining pages are spread over four external banks. Each bank begins at a page held in a writable start register, so the bank boundaries can be moved. I/O accesses assert the I/O select, and a separate flag reports whether the I/O address falls in the on-chip peripheral window below 8K.

The block is one request state register with four states. ST_IDLE means no request was taken. ST_DATA, ST_BRANCH and ST_IO name the kind of request taken on the last edge. Each edge moves from any state to the state of the highest-priority request present, or to ST_IDLE when none is present. The composed address and the selects are registered in the same edge.

Top module: `pgaddr_unit`

## Requirements
- R1: After reset every page register reads zero. The bank start registers hold 1, 64, 128 and 192 for banks 0 to 3. The state is ST_IDLE, so out_valid and every select are low.
- R2: A data request gives out_addr = {data page register selected by d_sel, d_index}.
- R3: A branch request gives out_addr = {branch page register, b_value}.
- R4: An I/O request gives out_addr bits 17:0 = {I/O page register, io_imm}, with bits 23:18 zero, and asserts sel_io only.
- R5: io_onchip is high for an I/O request whose 18-bit address is below 8192, and low otherwise.
- R6: For a data or branch request, page 0 asserts sel_int and page 255 asserts sel_boot.
- R7: For a data or branch request on pages 1 to 254, the selected bank is the highest bank whose start register is at or below the page. sel_bank bit i means bank i. A page below every start goes to sel_int. With reset starts this gives bank 0 = 1..63, bank 1 = 64..127, bank 2 = 128..191 and bank 3 = 192..254.
- R8: A register write takes effect on the edge that samples it. A request in the same cycle still uses the old value, and the next request uses the new value.
- R9: Results appear one clock after the request. out_valid marks them, and exactly one of sel_int, sel_boot, sel_bank and sel_io is high. With no request, out_valid and all selects are low.
- R10: When several requests coincide, a data request wins over a branch request, and a branch request wins over an I/O request.
- R11: The write address map is 0 to NUM_DAG-1 for the data page registers, 4 for the branch page, 5 for the I/O page, and 8+i for the start of bank i. A write to any other address changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write address |
| cfg_wdata | input | 8 | Register write data |
| d_req | input | 1 | Data access request |
| d_sel | input | 1 | Which data page register to use |
| d_index | input | 16 | Data index value |
| b_req | input | 1 | Indirect branch request |
| b_value | input | 16 | Branch register value |
| io_req | input | 1 | I/O access request |
| io_imm | input | 10 | I/O immediate |
| out_valid | output | 1 | Registered result is valid |
| out_addr | output | 24 | Composed address |
| sel_int | output | 1 | Internal memory select |
| sel_boot | output | 1 | Boot ROM select |
| sel_bank | output | 4 | External bank selects, bit i is bank i |
| sel_io | output | 1 | I/O space select |
| io_onchip | output | 1 | I/O address lies in the on-chip window |

## Verification
The hardest state to reach from the ports is a moved bank layout, where the start registers no longer match the reset ranges. In that layout the pages below the first bank fall back to internal memory. The stimulus writes new starts, then sweeps every page through a data page register and compares each decode against a bank lookup done in the bench. The same-cycle write case, where a page write and a request share one edge, is driven on purpose to show that the old page is used.

// File: rtl/pgaddr_pkg.sv
package pgaddr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DATA   = 2'd1,
        ST_BRANCH = 2'd2,
        ST_IO     = 2'd3
    } pg_state_e;

    localparam int CFG_BRANCH    = 4;
    localparam int CFG_IO        = 5;
    localparam int CFG_BANK_BASE = 8;
endpackage

// File: rtl/pgaddr_regs.sv
module pgaddr_regs
    import pgaddr_pkg::*;
#(
    parameter int PAGE_W   = 8,
    parameter int NUM_DAG  = 2,
    parameter int NUM_BANK = 4,
    parameter int CFG_AW   = 4
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               cfg_we,
    input  logic [CFG_AW-1:0]                  cfg_addr,
    input  logic [PAGE_W-1:0]                  cfg_wdata,
    output logic [NUM_DAG-1:0][PAGE_W-1:0]     dpage,
    output logic [PAGE_W-1:0]                  bpage,
    output logic [PAGE_W-1:0]                  iopage,
    output logic [NUM_BANK-1:0][PAGE_W-1:0]    bstart
);
    localparam int PAGES_PER_BANK = (2 ** PAGE_W) / NUM_BANK;

    for (genvar g = 0; g < NUM_DAG; g++) begin : g_dpage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dpage[g] <= '0;
            else if (cfg_we && cfg_addr == CFG_AW'(g))
                dpage[g] <= cfg_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bpage <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(CFG_BRANCH))
            bpage <= cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            iopage <= '0;
        else if (cfg_we && cfg_addr == CFG_AW'(CFG_IO))
            iopage <= cfg_wdata;
    end

    for (genvar g = 0; g < NUM_BANK; g++) begin : g_bstart
        localparam logic [PAGE_W-1:0] RST_START =
            (g == 0) ? PAGE_W'(1) : PAGE_W'(g * PAGES_PER_BANK);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                bstart[g] <= RST_START;
            else if (cfg_we && cfg_addr == CFG_AW'(CFG_BANK_BASE + g))
                bstart[g] <= cfg_wdata;
        end
    end
endmodule

// File: rtl/pgaddr_compose.sv
module pgaddr_compose
    import pgaddr_pkg::*;
#(
    parameter int PAGE_W  = 8,
    parameter int OFS_W   = 16,
    parameter int IMM_W   = 10,
    parameter int NUM_DAG = 2,
    parameter int DSEL_W  = 1,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input  pg_state_e                       kind,
    input  logic [NUM_DAG-1:0][PAGE_W-1:0]  dpage,
    input  logic [PAGE_W-1:0]               bpage,
    input  logic [PAGE_W-1:0]               iopage,
    input  logic [DSEL_W-1:0]               d_sel,
    input  logic [OFS_W-1:0]                d_index,
    input  logic [OFS_W-1:0]                b_value,
    input  logic [IMM_W-1:0]                io_imm,
    output logic [ADDR_W-1:0]               addr
);
    always_comb begin
        unique case (kind)
            ST_DATA:   addr = {dpage[d_sel], d_index};
            ST_BRANCH: addr = {bpage, b_value};
            ST_IO:     addr = ADDR_W'({iopage, io_imm});
            default:   addr = '0;
        endcase
    end
endmodule

// File: rtl/pgaddr_decode.sv
module pgaddr_decode
    import pgaddr_pkg::*;
#(
    parameter int PAGE_W        = 8,
    parameter int OFS_W         = 16,
    parameter int IMM_W         = 10,
    parameter int NUM_BANK      = 4,
    parameter int ONCHIP_LIMIT  = 8192,
    localparam int ADDR_W = PAGE_W + OFS_W,
    localparam int IO_W   = PAGE_W + IMM_W
) (
    input  pg_state_e                       kind,
    input  logic [ADDR_W-1:0]               addr,
    input  logic [NUM_BANK-1:0][PAGE_W-1:0] bstart,
    output logic                            sel_int,
    output logic                            sel_boot,
    output logic [NUM_BANK-1:0]             sel_bank,
    output logic                            sel_io,
    output logic                            io_onchip
);
    localparam logic [PAGE_W-1:0] BOOT_PAGE = '1;

    logic [PAGE_W-1:0]   page;
    logic [NUM_BANK-1:0] ge;
    logic [NUM_BANK-1:0] hit;
    logic                mem_kind;
    logic                edge_page;

    assign page      = addr[ADDR_W-1:OFS_W];
    assign mem_kind  = (kind == ST_DATA) || (kind == ST_BRANCH);
    assign edge_page = (page == '0) || (page == BOOT_PAGE);

    for (genvar i = 0; i < NUM_BANK; i++) begin : g_match
        assign ge[i] = (page >= bstart[i]);
        if (i == NUM_BANK - 1) begin : g_top
            assign hit[i] = ge[i];
        end else begin : g_low
            assign hit[i] = ge[i] && !(|ge[NUM_BANK-1:i+1]);
        end
    end

    always_comb begin
        sel_int   = 1'b0;
        sel_boot  = 1'b0;
        sel_bank  = '0;
        sel_io    = 1'b0;
        io_onchip = 1'b0;
        if (mem_kind) begin
            if (page == BOOT_PAGE)
                sel_boot = 1'b1;
            else if (edge_page || !(|ge))
                sel_int = 1'b1;
            else
                sel_bank = hit;
        end else if (kind == ST_IO) begin
            sel_io    = 1'b1;
            io_onchip = (addr[IO_W-1:0] < IO_W'(ONCHIP_LIMIT));
        end
    end
endmodule

// File: rtl/pgaddr_unit.sv
module pgaddr_unit
    import pgaddr_pkg::*;
#(
    parameter int PAGE_W       = 8,
    parameter int OFS_W        = 16,
    parameter int IMM_W        = 10,
    parameter int NUM_DAG      = 2,
    parameter int NUM_BANK     = 4,
    parameter int CFG_AW       = 4,
    parameter int ONCHIP_LIMIT = 8192,
    localparam int ADDR_W = PAGE_W + OFS_W,
    localparam int DSEL_W = (NUM_DAG > 1) ? $clog2(NUM_DAG) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [PAGE_W-1:0]    cfg_wdata,
    input  logic                 d_req,
    input  logic [DSEL_W-1:0]    d_sel,
    input  logic [OFS_W-1:0]     d_index,
    input  logic                 b_req,
    input  logic [OFS_W-1:0]     b_value,
    input  logic                 io_req,
    input  logic [IMM_W-1:0]     io_imm,
    output logic                 out_valid,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 sel_int,
    output logic                 sel_boot,
    output logic [NUM_BANK-1:0]  sel_bank,
    output logic                 sel_io,
    output logic                 io_onchip
);
    pg_state_e state_q, state_d;

    logic [NUM_DAG-1:0][PAGE_W-1:0]  dpage;
    logic [PAGE_W-1:0]               bpage;
    logic [PAGE_W-1:0]               iopage;
    logic [NUM_BANK-1:0][PAGE_W-1:0] bstart;
    logic [ADDR_W-1:0]               addr_d;
    logic                            int_d, boot_d, io_d, onchip_d;
    logic [NUM_BANK-1:0]             bank_d;

    pgaddr_regs #(
        .PAGE_W(PAGE_W), .NUM_DAG(NUM_DAG), .NUM_BANK(NUM_BANK), .CFG_AW(CFG_AW)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .dpage(dpage), .bpage(bpage),
        .iopage(iopage), .bstart(bstart)
    );

    // Next state: highest-priority request present this cycle
    always_comb begin
        if (d_req)
            state_d = ST_DATA;
        else if (b_req)
            state_d = ST_BRANCH;
        else if (io_req)
            state_d = ST_IO;
        else
            state_d = ST_IDLE;
    end

    pgaddr_compose #(
        .PAGE_W(PAGE_W), .OFS_W(OFS_W), .IMM_W(IMM_W),
        .NUM_DAG(NUM_DAG), .DSEL_W(DSEL_W)
    ) u_compose (
        .kind(state_d), .dpage(dpage), .bpage(bpage), .iopage(iopage),
        .d_sel(d_sel), .d_index(d_index), .b_value(b_value),
        .io_imm(io_imm), .addr(addr_d)
    );

    pgaddr_decode #(
        .PAGE_W(PAGE_W), .OFS_W(OFS_W), .IMM_W(IMM_W),
        .NUM_BANK(NUM_BANK), .ONCHIP_LIMIT(ONCHIP_LIMIT)
    ) u_decode (
        .kind(state_d), .addr(addr_d), .bstart(bstart),
        .sel_int(int_d), .sel_boot(boot_d), .sel_bank(bank_d),
        .sel_io(io_d), .io_onchip(onchip_d)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_addr  <= '0;
            sel_int   <= 1'b0;
            sel_boot  <= 1'b0;
            sel_bank  <= '0;
            sel_io    <= 1'b0;
            io_onchip <= 1'b0;
        end else begin
            out_addr  <= addr_d;
            sel_int   <= int_d;
            sel_boot  <= boot_d;
            sel_bank  <= bank_d;
            sel_io    <= io_d;
            io_onchip <= onchip_d;
        end
    end

    assign out_valid = (state_q != ST_IDLE);
endmodule

// File: rtl/pgaddr_chk.sv
module pgaddr_chk #(
    parameter int PAGE_W   = 8,
    parameter int OFS_W    = 16,
    parameter int NUM_BANK = 4,
    localparam int ADDR_W = PAGE_W + OFS_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                d_req,
    input logic                b_req,
    input logic                io_req,
    input logic [OFS_W-1:0]    b_value,
    input logic                out_valid,
    input logic [ADDR_W-1:0]   out_addr,
    input logic                sel_int,
    input logic                sel_boot,
    input logic [NUM_BANK-1:0] sel_bank,
    input logic                sel_io,
    input logic                io_onchip
);
    logic [NUM_BANK+2:0] sels;
    assign sels = {sel_int, sel_boot, sel_bank, sel_io};

    p_one_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(sels) == 1);

    p_no_sel_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> sels == '0);

    p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (d_req || b_req || io_req) |=> out_valid);

    p_onchip_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
        io_onchip |-> sel_io);

    p_io_high_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_io |-> out_addr[ADDR_W-1:18] == '0);

    p_boot_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sel_io && out_addr[ADDR_W-1:OFS_W] == '1) |-> sel_boot);

    p_int_page_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sel_io && out_addr[ADDR_W-1:OFS_W] == '0) |-> sel_int);

    p_branch_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_req && !d_req) |=> out_addr[OFS_W-1:0] == $past(b_value));

    p_io_prio_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (io_req && (d_req || b_req)) |=> !sel_io);
endmodule

bind pgaddr_unit pgaddr_chk #(
    .PAGE_W(PAGE_W), .OFS_W(OFS_W), .NUM_BANK(NUM_BANK)
) u_chk (.*);

// File: tb/sim_pgaddr_unit.sv
module sim_pgaddr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [7:0]  cfg_wdata = '0;
    logic        d_req = 1'b0;
    logic [0:0]  d_sel = '0;
    logic [15:0] d_index = '0;
    logic        b_req = 1'b0;
    logic [15:0] b_value = '0;
    logic        io_req = 1'b0;
    logic [9:0]  io_imm = '0;
    logic        out_valid;
    logic [23:0] out_addr;
    logic        sel_int, sel_boot, sel_io, io_onchip;
    logic [3:0]  sel_bank;

    int vectors = 0;
    int errors  = 0;
    int starts [4] = '{1, 64, 128, 192};

    always #10 clk = ~clk;

    pgaddr_unit u0 (.*);

    // select word: {io_onchip, sel_io, sel_bank[3:0], sel_boot, sel_int}
    function automatic logic [7:0] mem_sel(input int page);
        int b;
        if (page == 255) return 8'b0000_0010;
        if (page == 0)   return 8'b0000_0001;
        b = -1;
        for (int i = 0; i < 4; i++) if (page >= starts[i]) b = i;
        if (b < 0) return 8'b0000_0001;
        return 8'(1 << (b + 2));
    endfunction

    task automatic check(input string req, input logic ev,
                         input logic [23:0] ea, input logic [7:0] es);
        logic [7:0] as;
        as = {io_onchip, sel_io, sel_bank, sel_boot, sel_int};
        vectors++;
        if (out_valid !== ev || (ev && out_addr !== ea) || as !== es) begin
            errors++;
            $display("FAIL %s: valid=%0b addr=%06h sel=%08b expected valid=%0b addr=%06h sel=%08b",
                     req, out_valid, out_addr, as, ev, ea, es);
        end
    endtask

    task automatic cfg(input int a, input int v);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_wdata = 8'(v);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic req(input logic dq, input int ds, input int di,
                       input logic bq, input int bv, input logic iq, input int im);
        d_req = dq; d_sel = 1'(ds); d_index = 16'(di);
        b_req = bq; b_value = 16'(bv);
        io_req = iq; io_imm = 10'(im);
        @(negedge clk);
        d_req = 1'b0; b_req = 1'b0; io_req = 1'b0;
    endtask

    task automatic sweep_data(input string tag);
        for (int p = 0; p < 256; p++) begin
            cfg(0, p);
            req(1, 0, p * 251 + 7, 0, 0, 0, 0);
            check(tag, 1'b1, {8'(p), 16'(p * 251 + 7)}, mem_sel(p));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        logic [17:0] ioa;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset idle", 1'b0, 24'h0, 8'h00);
        // R1: reset pages zero
        req(1, 1, 16'hBEEF, 0, 0, 0, 0);
        check("R1 data page1 reset zero", 1'b1, 24'h00BEEF, 8'h01);
        req(0, 0, 0, 1, 16'h1234, 0, 0);
        check("R1 branch page reset zero", 1'b1, 24'h001234, 8'h01);
        // R2, R6, R7: every page through data page 0, reset bank starts
        sweep_data("R7 R6 R2 data sweep reset banks");
        // R2: second data page register
        for (int p = 0; p < 256; p += 17) begin
            cfg(1, p);
            req(1, 1, 16'hA5A5 ^ p, 0, 0, 0, 0);
            check("R2 data page1", 1'b1, {8'(p), 16'(16'hA5A5 ^ p)}, mem_sel(p));
        end
        // R3: branch sweep
        for (int p = 0; p < 256; p += 5) begin
            cfg(4, p);
            req(0, 0, 0, 1, p * 97, 0, 0);
            check("R3 branch", 1'b1, {8'(p), 16'(p * 97)}, mem_sel(p));
        end
        // R4, R5: I/O sweep
        for (int p = 0; p < 256; p++) begin
            cfg(5, p);
            for (int k = 0; k < 2; k++) begin
                ioa = {8'(p), 10'(k * 1023)};
                req(0, 0, 0, 0, 0, 1, k * 1023);
                check("R4 R5 io", 1'b1, {6'h0, ioa},
                      {(ioa < 18'd8192), 1'b1, 6'h0});
            end
        end
        // R9: idle cycle
        req(0, 0, 0, 0, 0, 0, 0);
        check("R9 no request", 1'b0, 24'h0, 8'h00);
        // R10: priority
        cfg(0, 8'h50); cfg(4, 8'hC8); cfg(5, 8'h03);
        req(1, 0, 16'h0101, 1, 16'h0202, 1, 10'h3);
        check("R10 data over all", 1'b1, 24'h500101, mem_sel(8'h50));
        req(0, 0, 0, 1, 16'h0303, 1, 10'h4);
        check("R10 branch over io", 1'b1, 24'hC80303, mem_sel(8'hC8));
        // R8: same-cycle write uses old page
        cfg_we = 1'b1; cfg_addr = 4'd0; cfg_wdata = 8'h55;
        req(1, 0, 16'h7777, 0, 0, 0, 0);
        cfg_we = 1'b0;
        check("R8 same-cycle old page", 1'b1, 24'h507777, mem_sel(8'h50));
        req(1, 0, 16'h8888, 0, 0, 0, 0);
        check("R8 next request new page", 1'b1, 24'h558888, mem_sel(8'h55));
        // R11: unmapped writes change nothing
        cfg(1, 8'h11);
        cfg(2, 8'hAA); cfg(3, 8'hAA); cfg(6, 8'hAA); cfg(7, 8'hAA);
        cfg(12, 8'hAA); cfg(15, 8'hAA);
        req(1, 0, 1, 0, 0, 0, 0);
        check("R11 data0 unchanged", 1'b1, 24'h550001, mem_sel(8'h55));
        req(1, 1, 2, 0, 0, 0, 0);
        check("R11 data1 unchanged", 1'b1, 24'h110002, mem_sel(8'h11));
        req(0, 0, 0, 1, 3, 0, 0);
        check("R11 branch unchanged", 1'b1, 24'hC80003, mem_sel(8'hC8));
        req(0, 0, 0, 0, 0, 1, 4);
        check("R11 io unchanged", 1'b1, {6'h0, 8'h03, 10'd4}, 8'hC0);
        sweep_data("R11 banks unchanged");
        // R7: moved boundaries
        starts = '{10, 20, 200, 250};
        cfg(8, 10); cfg(9, 20); cfg(10, 200); cfg(11, 250);
        sweep_data("R7 moved banks");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule